// File: doc/BRIEF.md
# Diagnostic Control Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial-bus target, clocked by the system clock, that oversamples the bus lines. A host writes a short run of instruction bytes into it to configure an amplifier diagnostics subsystem, and reads back a fixed run of status bytes that the diagnostic engines produce. The device answers one fixed 7-bit address. Bit 0 of the address byte selects the direction: 0 means the host writes and 1 means the host reads.

A read does not sample the live status lines byte by byte. Once the read address has been acknowledged, all status bytes are copied into a shadow register, and the bytes on the bus come from that copy. When a read ends, the block sends a one-cycle re-arm pulse to the diagnostic engines, which then start a new measurement cycle. The host therefore always sees the result of the cycle that was running before its read. A change in status shows up on the second read after the change.

Both bus lines pass through synchronizer flops. The data line is driven open-drain: the block either pulls it low or releases it.

The control FSM states are:

- `ST_IDLE`: the bus is not in use.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: the block pulls the data line low to acknowledge.
- `ST_WR_BYTE`: shifting in an instruction byte.
- `ST_WR_ACK`: acknowledging an instruction byte.
- `ST_RD_BYTE`: shifting out a status byte.
- `ST_RD_ACK`: sampling the host's acknowledge.
- `ST_WAIT_STOP`: the block is released and ignores the bus.

The FSM transitions are:

- A start condition moves any state to `ST_ADDR`. A stop condition moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, or to `ST_WAIT_STOP` on any other address.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` or `ST_RD_BYTE`, depending on the direction bit.
- `ST_WR_BYTE` goes to `ST_WR_ACK` while instruction slots remain, and to `ST_WAIT_STOP` once they are used up.
- `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on a host ACK while status bytes remain. Otherwise it goes to `ST_WAIT_STOP`.

Top module: `diag_i2c_slave`

## Requirements
- R1: After reset, every instruction byte reads 0, the data line is released (`sda_drive_low_o` = 0), and `rearm_o` is low.
- R2: Only the address 1101100 is acknowledged, that is 0xD8 for a write and 0xD9 for a read. For any other address the block never pulls the data line low for the rest of the transfer, and no instruction byte changes.
- R3: In a write, the first data byte after the address lands in instruction byte 0 (`ctrl_o[7:0]`) and the second lands in instruction byte 1 (`ctrl_o[15:8]`). The block acknowledges each one by holding the data line low during the ninth clock.
- R4: Data bytes beyond the second in a write are not acknowledged and change no instruction byte.
- R5: A read returns the four status bytes, most significant bit first, in the order `stat_i[7:0]`, `stat_i[15:8]`, `stat_i[23:16]`, `stat_i[31:24]`.
- R6: The status bytes are captured when the read address is acknowledged. Changes on `stat_i` after that point do not reach the bytes sent in the same read.
- R7: In the third status byte, bit 7 is replaced by instruction byte 1 bit 4 (standby control) and bit 6 by instruction byte 0 bit 6 (diagnostic enable), as they stand at capture.
- R8: `rearm_o` pulses for exactly one cycle when a stop ends a read whose address was acknowledged. A write, or a read to a wrong address, gives no pulse.
- R9: If the host answers a status byte with NACK, the block releases the data line for the rest of the transfer. Extra clocks read as all ones, and the closing stop still pulses `rearm_o`.
- R10: A repeated start ends a read in progress with a `rearm_o` pulse and begins a new address phase. A write that follows it works normally.
- R11: `sda_drive_low_o` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_drive_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| ctrl_o | output | NUM_WR*8 | Instruction bytes; byte k at bits [8k+7:8k] |
| stat_i | input | NUM_RD*8 | Live status bytes; byte k at bits [8k+7:8k], byte 0 sent first |
| rearm_o | output | 1 | One-cycle pulse that restarts all diagnostic cycles |

## Verification
The bench targets four ways the block can go wrong:

- **Third write byte.** If the byte counter wraps or is off by one, the third byte overwrites instruction byte 0 or gets acknowledged.
- **Status changes mid-read.** A design that samples `stat_i` per byte rather than at the address acknowledge returns a mix of old and new data.
- **Early host NACK.** A block that keeps shifting after the NACK pulls the line low and corrupts the bus.
- **Re-arm timing.** The pulse is checked after a plain stop, after a repeated start, after writes and after a rejected address. A design that re-arms on every stop, or never on a repeated start, shows a wrong pulse count.

// File: rtl/diag_i2c_pkg.sv
package diag_i2c_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } bus_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/diag_i2c_sync.sv
module diag_i2c_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                end
            end
            assign dout[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/diag_i2c_events.sv
module diag_i2c_events
    import diag_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/diag_i2c_engine.sv
module diag_i2c_engine
    import diag_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h6C,
    parameter int unsigned NUM_WR   = 2,
    parameter int unsigned NUM_RD   = 4,
    parameter int unsigned IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              snap_en,
    output logic [IDX_W-1:0]  rd_sel,
    output logic              sda_low,
    output logic              rearm
);

    localparam int unsigned      CNT_W   = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0] WR_LIM  = IDX_W'(NUM_WR);
    localparam logic [IDX_W-1:0] RD_LAST = IDX_W'(NUM_RD - 1);

    bus_state_e state;
    bus_state_e nxt;

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [IDX_W-1:0]  idx;
    logic              rw;
    logic              host_ack;
    logic              rd_active;
    logic              rearm_q;

    logic byte_done;
    logic addr_hit;

    assign byte_done = evt.scl_fall && (cnt == CNT_END);
    assign addr_hit  = (shreg[BYTE_W-1:1] == DEV_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (evt.stop) begin
            nxt = ST_IDLE;
        end else if (evt.start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_WAIT_STOP;
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) nxt = rw ? ST_RD_BYTE : ST_WR_BYTE;
                end
                ST_WR_BYTE: begin
                    if (byte_done) nxt = (idx < WR_LIM) ? ST_WR_ACK : ST_WAIT_STOP;
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) nxt = ST_WR_BYTE;
                end
                ST_RD_BYTE: begin
                    if (byte_done) nxt = ST_RD_ACK;
                end
                ST_RD_ACK: begin
                    if (evt.scl_fall) nxt = (host_ack && idx < RD_LAST) ? ST_RD_BYTE : ST_WAIT_STOP;
                end
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shifters, byte index, read tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            txsh      <= '1;
            idx       <= '0;
            rw        <= 1'b0;
            host_ack  <= 1'b0;
            rd_active <= 1'b0;
            rearm_q   <= 1'b0;
        end else if (evt.start || evt.stop) begin
            cnt       <= '0;
            idx       <= '0;
            txsh      <= '1;
            rearm_q   <= rd_active;
            rd_active <= 1'b0;
        end else begin
            rearm_q <= 1'b0;
            if (snap_en) rd_active <= 1'b1;
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (evt.scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], evt.sda};
                        cnt   <= cnt + 1'b1;
                    end
                    if (state == ST_ADDR && byte_done) rw <= shreg[0];
                end
                ST_ADDR_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        idx <= '0;
                        if (rw) txsh <= tx_byte;
                    end
                end
                ST_WR_ACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        idx <= idx + 1'b1;
                    end
                end
                ST_RD_BYTE: begin
                    if (evt.scl_rise) cnt <= cnt + 1'b1;
                    if (evt.scl_fall) begin
                        if (cnt == CNT_END) txsh <= '1;
                        else txsh <= {txsh[BYTE_W-2:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (evt.scl_rise) host_ack <= ~evt.sda;
                    if (evt.scl_fall && host_ack && idx < RD_LAST) begin
                        idx  <= idx + 1'b1;
                        txsh <= tx_byte;
                        cnt  <= '0;
                    end
                end
                ST_IDLE, ST_WAIT_STOP: begin
                    cnt <= '0;
                end
                default: cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = (state == ST_WR_BYTE) && byte_done && (idx < WR_LIM);
        wr_idx  = idx;
        wr_data = shreg;
        snap_en = (state == ST_ADDR) && byte_done && addr_hit && shreg[0];
        rd_sel  = (state == ST_RD_ACK) ? idx + 1'b1 : idx;
        rearm   = rearm_q;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_low = 1'b1;
            ST_RD_BYTE:             sda_low = ~txsh[BYTE_W-1];
            default:                sda_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/diag_i2c_regs.sv
module diag_i2c_regs
    import diag_i2c_pkg::*;
#(
    parameter int unsigned NUM_WR      = 2,
    parameter int unsigned NUM_RD      = 4,
    parameter int unsigned IDX_W       = 3,
    parameter int unsigned MIRROR_BYTE = 2,
    parameter int unsigned STBY_BYTE   = 1,
    parameter int unsigned STBY_BIT    = 4,
    parameter int unsigned DIAG_BYTE   = 0,
    parameter int unsigned DIAG_BIT    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     snap_en,
    input  logic [NUM_RD*BYTE_W-1:0] stat_i,
    input  logic [IDX_W-1:0]         rd_sel,
    output logic [BYTE_W-1:0]        tx_byte,
    output logic [NUM_WR*BYTE_W-1:0] ctrl_o
);

    logic [BYTE_W-1:0] ctrl_q [NUM_WR];
    logic [BYTE_W-1:0] shadow [NUM_RD];

    genvar w, r;
    generate
        for (w = 0; w < NUM_WR; w++) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctrl_q[w] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(w)) begin
                    ctrl_q[w] <= wr_data;
                end
            end
            assign ctrl_o[w*BYTE_W +: BYTE_W] = ctrl_q[w];
        end

        for (r = 0; r < NUM_RD; r++) begin : g_shadow
            logic [BYTE_W-1:0] snap_val;
            if (r == MIRROR_BYTE) begin : g_mirror
                assign snap_val = {ctrl_q[STBY_BYTE][STBY_BIT],
                                   ctrl_q[DIAG_BYTE][DIAG_BIT],
                                   stat_i[r*BYTE_W +: BYTE_W-2]};
            end else begin : g_plain
                assign snap_val = stat_i[r*BYTE_W +: BYTE_W];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow[r] <= '0;
                end else if (snap_en) begin
                    shadow[r] <= snap_val;
                end
            end
        end
    endgenerate

    always_comb begin
        tx_byte = '1;
        for (int k = 0; k < NUM_RD; k++) begin
            if (rd_sel == IDX_W'(k)) tx_byte = shadow[k];
        end
    end

endmodule

// File: rtl/diag_i2c_slave.sv
module diag_i2c_slave
    import diag_i2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h6C,
    parameter int unsigned NUM_WR      = 2,
    parameter int unsigned NUM_RD      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_drive_low_o,
    output logic [NUM_WR*BYTE_W-1:0] ctrl_o,
    input  logic [NUM_RD*BYTE_W-1:0] stat_i,
    output logic                     rearm_o
);

    localparam int unsigned MAXB  = (NUM_RD > NUM_WR) ? NUM_RD : NUM_WR;
    localparam int unsigned IDX_W = $clog2(MAXB + 1);

    logic [1:0]        lines_s;
    bus_evt_t          evt;
    logic [BYTE_W-1:0] tx_byte;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              snap_en;
    logic [IDX_W-1:0]  rd_sel;

    diag_i2c_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .dout  (lines_s)
    );

    diag_i2c_events u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .evt   (evt)
    );

    diag_i2c_engine #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_WR   (NUM_WR),
        .NUM_RD   (NUM_RD),
        .IDX_W    (IDX_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .tx_byte (tx_byte),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .snap_en (snap_en),
        .rd_sel  (rd_sel),
        .sda_low (sda_drive_low_o),
        .rearm   (rearm_o)
    );

    diag_i2c_regs #(
        .NUM_WR (NUM_WR),
        .NUM_RD (NUM_RD),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .snap_en (snap_en),
        .stat_i  (stat_i),
        .rd_sel  (rd_sel),
        .tx_byte (tx_byte),
        .ctrl_o  (ctrl_o)
    );

endmodule

// File: rtl/diag_i2c_slave_chk.sv
module diag_i2c_slave_chk #(
    parameter int unsigned CTRL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_drive_low_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic              rearm_o
);

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !scl_i); // R11

    AST_REARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |=> !rearm_o); // R8

    AST_REARM_ON_BUS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_o |-> (scl_i && !sda_drive_low_o)); // R10

    AST_CTRL_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> sda_drive_low_o); // R3

    AST_CTRL_WRITE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> !scl_i); // R4

endmodule

bind diag_i2c_slave diag_i2c_slave_chk #(
    .CTRL_W (NUM_WR * 8)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (scl_i),
    .sda_drive_low_o (sda_drive_low_o),
    .ctrl_o          (ctrl_o),
    .rearm_o         (rearm_o)
);

// File: tb/diag_i2c_slave_tb.sv
module diag_i2c_slave_tb;

    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [31:0] stat = '0;
    logic        sda_drive_low_o;
    logic [15:0] ctrl_o;
    logic        rearm_o;
    wire         sda_bus = m_sda & ~sda_drive_low_o;

    int checks = 0;
    int fails = 0;
    int rearm_cnt = 0;
    int od_bad = 0;
    logic prev_low = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    diag_i2c_slave u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .sda_drive_low_o (sda_drive_low_o),
        .ctrl_o          (ctrl_o),
        .stat_i          (stat),
        .rearm_o         (rearm_o)
    );

    always @(posedge clk) begin
        if (rearm_o) rearm_cnt++;
        if (rst_n && sda_drive_low_o != prev_low && m_scl) od_bad++;
        prev_low <= sda_drive_low_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
        end
        m_sda = 1'b1; q(); m_scl = 1'b1; q(); ack = ~sda_bus; q(); m_scl = 1'b0; q();
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); m_scl = 1'b1; q(); b[i] = sda_bus; q(); m_scl = 1'b0;
        end
        q(); m_sda = ~give_ack; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q(); m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 ctrl", {16'h0, ctrl_o}, 32'h0);
        chk("R1 sda", {31'h0, sda_drive_low_o}, 32'h0);
        chk("R1 rearm", rearm_cnt, 0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start(); put_byte(8'hDA, a); chk("R2 write nack", {31'h0, a}, 32'h0);
        put_byte(8'h77, a); chk("R2 data nack", {31'h0, a}, 32'h0);
        bus_stop(); chk("R2 ctrl kept", {16'h0, ctrl_o}, 32'h0);
        bus_start(); put_byte(8'hDB, a); chk("R2 read nack", {31'h0, a}, 32'h0);
        bus_stop(); chk("R8 no rearm on bad addr", rearm_cnt, 0);
    endtask

    task automatic t_write_two();
        logic a0, a1, a2;
        bus_start(); put_byte(8'hD8, a0); put_byte(8'hA5, a1); put_byte(8'h3C, a2); bus_stop();
        chk("R3 acks", {29'h0, a0, a1, a2}, 32'h7);
        chk("R3 ctrl", {16'h0, ctrl_o}, 32'h3CA5);
        chk("R8 no rearm on write", rearm_cnt, 0);
    endtask

    task automatic t_write_three();
        logic a0, a1, a2, a3;
        bus_start(); put_byte(8'hD8, a0); put_byte(8'h40, a1); put_byte(8'h10, a2);
        put_byte(8'hEE, a3); bus_stop();
        chk("R4 third nack", {28'h0, a0, a1, a2, a3}, 32'hE);
        chk("R4 ctrl", {16'h0, ctrl_o}, 32'h1040);
    endtask

    task automatic t_read_all();
        logic a;
        logic [7:0] b [4];
        int r0;
        r0 = rearm_cnt;
        stat = 32'h9605_5AC1;
        bus_start(); put_byte(8'hD9, a);
        for (int k = 0; k < 4; k++) get_byte(k < 3, b[k]);
        bus_stop();
        chk("R5 addr ack", {31'h0, a}, 32'h1);
        chk("R5 order", {b[3], b[2], b[1], b[0]}, 32'h96C5_5AC1);
        chk("R7 mirror byte", {24'h0, b[2]}, 32'hC5);
        chk("R8 rearm after read", rearm_cnt, r0 + 1);
    endtask

    task automatic t_snapshot();
        logic a;
        logic [7:0] b [4];
        stat = 32'h1122_3344;
        bus_start(); put_byte(8'hD9, a);
        stat = 32'hFFFF_FFFF;
        for (int k = 0; k < 4; k++) get_byte(k < 3, b[k]);
        bus_stop();
        chk("R6 snapshot", {b[3], b[2], b[1], b[0]}, 32'h11E2_3344);
    endtask

    task automatic t_early_nack();
        logic a;
        logic [7:0] b0, b1, bx;
        int r0;
        r0 = rearm_cnt;
        stat = 32'h0000_0F0F;
        bus_start(); put_byte(8'hD9, a); get_byte(1'b1, b0); get_byte(1'b0, b1);
        get_byte(1'b0, bx);
        chk("R9 bytes before nack", {16'h0, b1, b0}, 32'h0F0F);
        chk("R9 released after nack", {24'h0, bx}, 32'hFF);
        bus_stop();
        chk("R9 rearm at stop", rearm_cnt, r0 + 1);
    endtask

    task automatic t_restart();
        logic a, a1, a2;
        logic [7:0] b0;
        int r0;
        r0 = rearm_cnt;
        bus_start(); put_byte(8'hD9, a); get_byte(1'b0, b0);
        bus_start();
        chk("R10 rearm on repeated start", rearm_cnt, r0 + 1);
        put_byte(8'hD8, a); put_byte(8'h00, a1); put_byte(8'h00, a2); bus_stop();
        chk("R10 write after restart", {13'h0, a, a1, a2, ctrl_o}, {13'h0, 3'b111, 16'h0});
        chk("R10 no extra rearm", rearm_cnt, r0 + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_wrong_addr();
        t_write_two();
        t_write_three();
        t_read_all();
        t_snapshot();
        t_early_nack();
        t_restart();
        chk("R11 open-drain edges", od_bad, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule